// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block turns a host's serial bit stream into byte-wide strobes for a display controller. The host drives an active-low chip select, a serial clock and a serial data line, plus an optional type pin. The receiver samples all of them in its own system clock domain and detects rising edges of the serial clock. It gathers bits most significant first and emits a one-cycle strobe for each finished byte. Each strobe carries the byte and a flag that says whether the byte is a command or display data.

Two framing modes are chosen by a static mode input. In four-wire mode the type pin decides the flag of each byte. In three-wire mode there is no type pin, so every byte is a command by default. The host opens a data window by sending the prefix byte 0xE8 followed by a count byte N. The next N bytes are then tagged as display data, and the stream goes back to commands after them. Releasing chip select at any point discards a partly received byte and closes any open window or pending count.

Top module: `serial_cmd_rx`

## Requirements
- R1: Serial data is sampled on rising edges of the serial clock while chip select is low. Bits are taken most significant first, and a byte is complete on the eighth rising edge.
- R2: While chip select is high, the bit counter and shift register are held cleared. A partial byte that was interrupted by deselect produces no strobe, and the next selected transfer starts a fresh byte.
- R3: With the mode input high (four-wire), every completed byte is forwarded. The data flag is 1 when the type pin is high at completion and 0 when it is low.
- R4: With the mode input low (three-wire), a completed byte is forwarded as a command (flag 0) unless it falls in a data window or is a prefix or count byte.
- R5: In three-wire mode, a byte equal to 0xE8 received in command state is a prefix. The prefix and the count byte that follows it are consumed and produce no strobe.
- R6: After a nonzero count N, exactly the next N bytes are forwarded with the data flag set, whatever their values. The byte after them is handled as a command again.
- R7: A count of zero opens no window, so the byte after it is a command.
- R8: Deselect at any point during a pending count or an open data window returns three-wire framing to command state.
- R9: Each forwarded byte produces out_valid high for exactly one clock, together with out_byte and out_is_data. The strobe is high after the third rising clk edge, counting the edge that first captures the eighth serial clock high (two synchronizer stages plus one output register). out_valid is low after reset.
- R10: In four-wire mode the value 0xE8 has no special meaning and is forwarded like any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (asynchronous to clk) |
| sck | input | 1 | Serial clock from host (asynchronous to clk) |
| sdi | input | 1 | Serial data, MSB first |
| dc_sel | input | 1 | Type pin for four-wire mode: 1 data, 0 command |
| four_wire | input | 1 | Framing mode: 1 four-wire, 0 three-wire (static while selected) |
| out_valid | output | 1 | One-cycle strobe per forwarded byte |
| out_is_data | output | 1 | Tag of the strobed byte: 1 display data, 0 command |
| out_byte | output | 8 | Received byte value |

## Verification
Every forwarded byte is due on out_valid three clk edges after the eighth serial clock rise is presented at the pins. The bench stamps each expected strobe with that cycle number when it drives the rising edge, in a queue built by a behavioural framing model. At every falling clk edge the bench compares out_valid, out_is_data and out_byte with the head of that queue. In every cycle with no strobe due, out_valid must be low. This is how consumed prefix and count bytes, aborted partial bytes and deselects inside a window are checked at the ports.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t WINDOW_PREFIX = 8'hE8;

  typedef enum logic [1:0] {
    RX_CMD   = 2'd0,
    RX_COUNT = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

  function automatic byte_t shift_in(byte_t cur, logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  function automatic logic is_prefix(byte_t b);
    return b == WINDOW_PREFIX;
  endfunction

  function automatic logic window_open(byte_t count);
    return count != '0;
  endfunction

  function automatic logic window_last(byte_t remaining);
    return remaining == byte_t'(1);
  endfunction

  function automatic byte_t window_step(byte_t remaining);
    return remaining - byte_t'(1);
  endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] q;
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= g_stg[i-1].q;
        end
      end
    end
  endgenerate

  assign d_out = g_stg[STAGES-1].q;

endmodule

// File: rtl/scr_shifter.sv
module scr_shifter
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_act,
  input  logic  sck_lvl,
  input  logic  sdi_lvl,
  output logic  byte_done,
  output byte_t byte_val
);

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

  logic                sck_prev;
  logic                sck_rise;
  logic [BITCNT_W-1:0] bit_cnt;
  byte_t               shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_lvl;
  end

  assign sck_rise = sck_lvl & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sck_rise) begin
      shreg   <= shift_in(shreg, sdi_lvl);
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign byte_done = cs_act && sck_rise && (bit_cnt == LAST_BIT);
  assign byte_val  = shift_in(shreg, sdi_lvl);

  // R2: deselect leaves the bit counter cleared
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));

  // R1: each sampled rising edge advances the bit position by one
  a_r1_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sck_rise && (bit_cnt != LAST_BIT)) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

  // R1: the MSB-first register takes the sampled bit into its low end
  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sck_rise) |=> (shreg[0] == $past(sdi_lvl)));

endmodule

// File: rtl/scr_tagger.sv
module scr_tagger
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_act,
  input  logic  four_wire,
  input  logic  dc_lvl,
  input  logic  byte_done,
  input  byte_t byte_val,
  output logic  out_valid,
  output logic  out_is_data,
  output byte_t out_byte
);

  rx_state_e state, nxt_state;
  byte_t     remaining, nxt_remaining;
  logic      fwd, fwd_data;

  always_comb begin
    nxt_state     = state;
    nxt_remaining = remaining;
    fwd           = 1'b0;
    fwd_data      = 1'b0;
    if (!cs_act) begin
      nxt_state     = RX_CMD;
      nxt_remaining = '0;
    end else if (byte_done) begin
      if (four_wire) begin
        fwd      = 1'b1;
        fwd_data = dc_lvl;
      end else begin
        unique case (state)
          RX_CMD: begin
            if (is_prefix(byte_val)) nxt_state = RX_COUNT;
            else                     fwd = 1'b1;
          end
          RX_COUNT: begin
            nxt_remaining = byte_val;
            nxt_state     = window_open(byte_val) ? RX_DATA : RX_CMD;
          end
          RX_DATA: begin
            fwd           = 1'b1;
            fwd_data      = 1'b1;
            nxt_remaining = window_step(remaining);
            if (window_last(remaining)) nxt_state = RX_CMD;
          end
          default: nxt_state = RX_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_CMD;
      remaining <= '0;
    end else begin
      state     <= nxt_state;
      remaining <= nxt_remaining;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_data <= 1'b0;
      out_byte    <= '0;
    end else begin
      out_valid <= fwd;
      if (fwd) begin
        out_is_data <= fwd_data;
        out_byte    <= byte_val;
      end
    end
  end

  // R9: strobes last one clock
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: deselect returns framing to command state
  a_r8_deselect_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state == RX_CMD));

  // R5: the count byte never produces a strobe
  a_r5_count_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && !four_wire && (state == RX_COUNT)) |=> !out_valid);

  // R3: four-wire tag follows the type pin at completion
  a_r3_tag_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && four_wire) |=> (out_valid && (out_is_data == $past(dc_lvl))));

  // R6: last byte of a window hands control back to commands
  a_r6_window_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && !four_wire && (state == RX_DATA) && window_last(remaining))
      |=> (state == RX_CMD));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dc_sel,
  input  logic              four_wire,
  output logic              out_valid,
  output logic              out_is_data,
  output logic [BYTE_W-1:0] out_byte
);

  localparam int PIN_W = 4;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             cs_act, sck_s, sdi_s, dc_s;
  logic             byte_done;
  byte_t            byte_val;

  assign pins_raw = {cs_n, sck, sdi, dc_sel};

  scr_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(4'b1000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pins_raw),
    .d_out(pins_s)
  );

  assign cs_act = ~pins_s[3];
  assign sck_s  = pins_s[2];
  assign sdi_s  = pins_s[1];
  assign dc_s   = pins_s[0];

  scr_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sck_lvl  (sck_s),
    .sdi_lvl  (sdi_s),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  scr_tagger u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .four_wire  (four_wire),
    .dc_lvl     (dc_s),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .out_valid  (out_valid),
    .out_is_data(out_is_data),
    .out_byte   (out_byte)
  );

  // R2: no byte completes while deselected
  a_r2_no_byte_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !byte_done);

endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int HALF       = 4;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, dc_sel = 1'b0, four_wire = 1'b1;
  logic       out_valid, out_is_data;
  logic [7:0] out_byte;

  serial_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dc_sel(dc_sel), .four_wire(four_wire),
    .out_valid(out_valid), .out_is_data(out_is_data), .out_byte(out_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    cyc = 0;
  int    errors = 0, checks = 0;
  bit    checking = 1'b0;
  string idle_tag = "R9";

  int         m_state = 0, m_rem = 0, m_nbits = 0;
  logic [7:0] m_acc = 8'h00;
  int         q_due[$];
  bit         q_dat[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Per-clock comparison against the expected-strobe queue
  always @(negedge clk) begin
    if (checking) begin
      if (q_due.size() > 0 && q_due[0] < cyc) begin
        chk(1'b0, q_tag[0], "missed strobe", 0, 1);
        void'(q_due.pop_front()); void'(q_dat.pop_front());
        void'(q_val.pop_front()); void'(q_tag.pop_front());
      end else if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(out_valid == 1'b1, q_tag[0], "out_valid", int'(out_valid), 1);
        chk(out_is_data == q_dat[0], q_tag[0], "out_is_data", int'(out_is_data), int'(q_dat[0]));
        chk(out_byte == q_val[0], q_tag[0], "out_byte", int'(out_byte), int'(q_val[0]));
        void'(q_due.pop_front()); void'(q_dat.pop_front());
        void'(q_val.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(out_valid == 1'b0, idle_tag, "unexpected out_valid", int'(out_valid), 0);
      end
    end
  end

  task automatic push(logic [7:0] v, bit dat, int due, string tag);
    q_due.push_back(due); q_dat.push_back(dat); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic model_byte(logic [7:0] v, bit dc, int due);
    if (four_wire) push(v, dc, due, "R3");
    else begin
      case (m_state)
        0: if (v == 8'hE8) m_state = 1; else push(v, 1'b0, due, "R4");
        1: begin m_rem = int'(v); m_state = (v == 8'h00) ? 0 : 2; end
        default: begin
          push(v, 1'b1, due, "R6");
          m_rem--;
          if (m_rem == 0) m_state = 0;
        end
      endcase
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int n, bit dc);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sdi = v[i]; dc_sel = dc; sck = 1'b0;
      tick(HALF - 1);
      @(negedge clk);
      sck = 1'b1;
      m_acc = {m_acc[6:0], v[i]};
      m_nbits++;
      if (m_nbits == 8) begin
        model_byte(m_acc, dc, cyc + LAT);
        m_nbits = 0;
      end
      tick(HALF - 1);
    end
    @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, bit dc);
    send_bits(v, 8, dc);
  endtask

  task automatic deselect();
    @(negedge clk);
    cs_n = 1'b1; sck = 1'b0;
    m_nbits = 0; m_acc = 8'h00; m_state = 0; m_rem = 0;
    tick(6);
  endtask

  task automatic select_chip();
    @(negedge clk);
    cs_n = 1'b0;
    tick(4);
  endtask

  initial begin
    tick(3);
    // R9: reset state of the outputs
    chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(out_byte == 8'h00, "R9", "reset out_byte", int'(out_byte), 0);
    chk(out_is_data == 1'b0, "R9", "reset out_is_data", int'(out_is_data), 0);
    rst_n = 1'b1;
    checking = 1'b1;
    tick(3);

    // R1 R3 R10: four-wire framing with both tags and the prefix value
    idle_tag = "R1";
    select_chip();
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b1);
    idle_tag = "R10";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h01, 1'b1);
    send_byte(8'h7E, 1'b0);

    // R2: partial byte is dropped on deselect
    idle_tag = "R2";
    send_bits(8'hFF, 3, 1'b1);
    deselect();
    select_chip();
    send_byte(8'h81, 1'b1);
    deselect();

    // R4 R5 R6: three-wire command, prefix, count and window
    four_wire = 1'b0;
    select_chip();
    idle_tag = "R4";
    send_byte(8'h12, 1'b0);
    idle_tag = "R5";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h03, 1'b0);
    idle_tag = "R6";
    send_byte(8'hD0, 1'b0);
    send_byte(8'hD1, 1'b0);
    send_byte(8'hD2, 1'b0);
    send_byte(8'h40, 1'b0);

    // R7: zero count opens no window
    idle_tag = "R7";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h00, 1'b0);
    send_byte(8'h55, 1'b0);

    // R6: prefix value inside a window is data
    idle_tag = "R6";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h02, 1'b0);
    send_byte(8'hE8, 1'b0);
    send_byte(8'h99, 1'b0);
    send_byte(8'hE8, 1'b0);
    send_byte(8'h01, 1'b0);
    send_byte(8'hAA, 1'b0);
    send_byte(8'hC3, 1'b0);

    // R8: deselect inside an open window
    idle_tag = "R8";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h05, 1'b0);
    send_byte(8'h11, 1'b0);
    send_byte(8'h22, 1'b0);
    deselect();
    select_chip();
    send_byte(8'h33, 1'b0);

    // R8: deselect while a count is pending
    send_byte(8'hE8, 1'b0);
    deselect();
    select_chip();
    send_byte(8'h07, 1'b0);

    // R2: deselect mid-byte inside a window drops the partial byte
    idle_tag = "R2";
    send_byte(8'hE8, 1'b0);
    send_byte(8'h04, 1'b0);
    send_bits(8'h5A, 5, 1'b0);
    deselect();
    select_chip();
    send_byte(8'h66, 1'b0);
    deselect();

    tick(10);
    chk(q_due.size() == 0, "R6", "pending strobes at end", q_due.size(), 0);
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule